// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is one bank of up to 32 general-purpose I/O lines behind a simple word-addressed register port. Each line works in one of three ways. It can be a plain input, a plain output, or an interrupt input. An interrupt input can detect a level or an edge, with selectable polarity, and can optionally fire on both edges. Pad inputs pass through a two-flop synchronizer before any logic uses them.

Each line has one status bit and one enable bit. An edge-mode status bit stays set until software writes a one to its bit in the clear register. A level-mode status bit follows the adjusted input. Software enables a line's interrupt either by writing the whole enable register or by writing ones to the unmask register. The single interrupt request is high whenever an enabled line has its status set.

The parameter `NUM_LINES` sets the number of implemented lines. A value of zero, or any value above 32, gives 32 lines. Register bits above the implemented count read as zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all configuration, output data, enable and status bits are zero, and `irq_o` and `pad_oe_o` are low.
- R2: Register word addresses are: 0 interrupt-mode select (1 = interrupt mode), 1 direction (1 = output), 2 polarity (1 = active low / falling), 3 trigger type (1 = edge, 0 = level), 4 both-edges, 5 output data, 6 input data (read only), 7 status (read only), 8 interrupt enable (1 = enabled), 9 clear strobe, 10 unmask strobe. Words 0–5 and 8 read back what was written. Words 9 and 10, and every word above 10, read as zero. Writes to 6 and 7 have no effect.
- R3: `pad_o` equals the output data register. `pad_oe_o[i]` is 1 exactly when line i has direction 1 and mode select 0.
- R4: Reading word 6 returns the output data bit for lines with direction 1. For the other lines it returns the pad value delayed by two clock edges through the synchronizer.
- R5: In level mode (mode 1, trigger 0), the status bit equals the synchronized pad XOR the polarity bit, one edge after the synchronizer output. A clear write does not remove it while the level persists.
- R6: In edge mode with both-edges 0, polarity 0 sets status on a rising synchronized input and polarity 1 on a falling one. The bit stays set until cleared.
- R7: In edge mode with both-edges 1, any change of the synchronized input sets status, whatever the polarity.
- R8: Writing word 9 clears the edge-mode status bits written as one. Zero bits have no effect. A detected edge in the same cycle as a clear of that line leaves the bit set.
- R9: Writing word 10 sets the enable bits written as one. Zero bits leave the enable unchanged.
- R10: `irq_o` is high exactly when the status register AND the enable register is non-zero.
- R11: A line with mode select 0 has a status bit of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_i | input | 32 | Pad input values |
| pad_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can act on one status bit in the same clock: an edge detected on a line, and a software clear of that line. A directed case provokes this. It schedules the pad transition so that the synchronized edge reaches the detector on the same edge that accepts a clear write to that line. The bit must then read back as set. The random phase also lands strobe writes and pad toggles on shared cycles. A cycle-level bench model of the synchronizer, detector and registers judges every readback and `irq_o`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int MAX_LINES = 32;
  localparam int ADDR_W    = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 4'd0,
    REG_DIR    = 4'd1,
    REG_POL    = 4'd2,
    REG_TRIG   = 4'd3,
    REG_BOTH   = 4'd4,
    REG_OUT    = 4'd5,
    REG_IN     = 4'd6,
    REG_STAT   = 4'd7,
    REG_EN     = 4'd8,
    REG_CLR    = 4'd9,
    REG_UNMASK = 4'd10
  } reg_addr_e;

  function automatic int eff_lines(int n);
    return (n <= 0 || n > MAX_LINES) ? MAX_LINES : n;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] evt;
  logic [N-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall;
    // compare raw history so a polarity change alone never fakes an edge
    assign rise   = sync_i[i] & ~prev_q[i];
    assign fall   = ~sync_i[i] & prev_q[i];
    assign evt[i] = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_q[i] <= 1'b0;
      else if (!mode_i[i]) status_q[i] <= 1'b0;
      else if (!trig_i[i]) status_q[i] <= sync_i[i] ^ pol_i[i];
      else                 status_q[i] <= evt[i] | (status_q[i] & ~clr_i[i]);
    end
  end

  assign status_o = status_q;

  AST_GPIO_IO_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(mode_i)) == '0)); // R11
  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q & mode_i & trig_i & ~clr_i) & ~status_q) == '0)); // R6
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt & mode_i & trig_i) & ~status_q) == '0)); // R8
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [MAX_LINES-1:0] wdata_i,
  input  logic [N-1:0]         sync_i,
  input  logic [N-1:0]         status_i,
  output logic [N-1:0]         mode_o,
  output logic [N-1:0]         dir_o,
  output logic [N-1:0]         pol_o,
  output logic [N-1:0]         trig_o,
  output logic [N-1:0]         both_o,
  output logic [N-1:0]         out_o,
  output logic [N-1:0]         en_o,
  output logic [N-1:0]         clr_o,
  output logic [MAX_LINES-1:0] rdata_o
);
  localparam int NREG = 7;

  logic [N-1:0] wd;
  logic [N-1:0] cfg_q [NREG];
  logic [N-1:0] rd;
  logic         unmask_wr;

  assign wd        = wdata_i[N-1:0];
  assign unmask_wr = wr_i && (addr_i == REG_UNMASK);
  assign clr_o     = (wr_i && addr_i == REG_CLR) ? wd : '0;

  // index 0..5 map to words 0..5, index 6 holds the enable word
  for (genvar r = 0; r < NREG; r++) begin : g_cfg
    localparam logic [ADDR_W-1:0] WORD = (r == NREG - 1) ? REG_EN : ADDR_W'(r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cfg_q[r] <= '0;
      else if (wr_i && addr_i == WORD)  cfg_q[r] <= wd;
      else if (r == NREG - 1 && unmask_wr) cfg_q[r] <= cfg_q[r] | wd;
    end
  end

  assign mode_o = cfg_q[0];
  assign dir_o  = cfg_q[1];
  assign pol_o  = cfg_q[2];
  assign trig_o = cfg_q[3];
  assign both_o = cfg_q[4];
  assign out_o  = cfg_q[5];
  assign en_o   = cfg_q[6];

  always_comb begin
    unique case (addr_i)
      REG_MODE: rd = cfg_q[0];
      REG_DIR:  rd = cfg_q[1];
      REG_POL:  rd = cfg_q[2];
      REG_TRIG: rd = cfg_q[3];
      REG_BOTH: rd = cfg_q[4];
      REG_OUT:  rd = cfg_q[5];
      REG_IN:   rd = (cfg_q[1] & cfg_q[5]) | (~cfg_q[1] & sync_i);
      REG_STAT: rd = status_i;
      REG_EN:   rd = cfg_q[6];
      default:  rd = '0;
    endcase
  end

  if (N < MAX_LINES) begin : g_pad_rd
    assign rdata_o = {{(MAX_LINES - N){1'b0}}, rd};
  end else begin : g_full_rd
    assign rdata_o = rd;
  end

  AST_UNMASK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmask_wr |=> (($past(wd) & ~en_o) == '0)); // R9
  AST_UNMASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmask_wr |=> (($past(en_o) & ~en_o) == '0)); // R9
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [MAX_LINES-1:0] wdata_i,
  output logic [MAX_LINES-1:0] rdata_o,
  input  logic [MAX_LINES-1:0] pad_i,
  output logic [MAX_LINES-1:0] pad_o,
  output logic [MAX_LINES-1:0] pad_oe_o,
  output logic                 irq_o
);
  localparam int N = eff_lines(NUM_LINES);

  logic [N-1:0] sync, mode, dir, pol, trig, both, outd, en, clr, status;
  logic [N-1:0] oe;

  gpio_sync #(.WIDTH(N), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i[N-1:0]), .q_o(sync)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(req_i & we_i), .addr_i, .wdata_i,
    .sync_i(sync), .status_i(status),
    .mode_o(mode), .dir_o(dir), .pol_o(pol), .trig_o(trig), .both_o(both),
    .out_o(outd), .en_o(en), .clr_o(clr), .rdata_o
  );

  gpio_irq_detect #(.N(N)) u_det (
    .clk_i, .rst_ni, .sync_i(sync),
    .mode_i(mode), .pol_i(pol), .trig_i(trig), .both_i(both), .clr_i(clr),
    .status_o(status)
  );

  assign oe    = dir & ~mode;
  assign irq_o = |(status & en);

  if (N < MAX_LINES) begin : g_pad_out
    assign pad_o    = {{(MAX_LINES - N){1'b0}}, outd};
    assign pad_oe_o = {{(MAX_LINES - N){1'b0}}, oe};
  end else begin : g_full_out
    assign pad_o    = outd;
    assign pad_oe_o = oe;
  end

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o); // R10
  AST_OE_ONLY_IO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o[N-1:0] & mode) == '0)); // R3
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad = '0, pad_o, pad_oe;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // bench model, built from the requirements
  logic [31:0] m_mode, m_dir, m_pol, m_trig, m_both, m_out, m_en, m_st;
  logic [31:0] m_s1, m_s2, m_prev;

  function automatic logic [31:0] evt_of(logic [31:0] s, logic [31:0] p,
                                         logic [31:0] pol, logic [31:0] both);
    logic [31:0] r = s & ~p, f = ~s & p;
    return (both & (r | f)) | (~both & ((pol & f) | (~pol & r)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_mode, m_dir, m_pol, m_trig, m_both, m_out, m_en, m_st} <= '0;
      {m_s1, m_s2, m_prev} <= '0;
    end else begin
      logic [31:0] ev, clr, nst;
      ev  = evt_of(m_s2, m_prev, m_pol, m_both);
      clr = (req && we && addr == 4'd9) ? wdata : '0;
      for (int i = 0; i < 32; i++) begin
        if (!m_mode[i])      nst[i] = 1'b0;
        else if (!m_trig[i]) nst[i] = m_s2[i] ^ m_pol[i];
        else                 nst[i] = ev[i] | (m_st[i] & ~clr[i]);
      end
      m_st <= nst;
      m_s1 <= pad; m_s2 <= m_s1; m_prev <= m_s2;
      if (req && we) begin
        case (addr)
          4'd0: m_mode <= wdata;
          4'd1: m_dir  <= wdata;
          4'd2: m_pol  <= wdata;
          4'd3: m_trig <= wdata;
          4'd4: m_both <= wdata;
          4'd5: m_out  <= wdata;
          4'd8: m_en   <= wdata;
          4'd10: m_en  <= m_en | wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return m_dir;
      4'd2: return m_pol;
      4'd3: return m_trig;
      4'd4: return m_both;
      4'd5: return m_out;
      4'd6: return (m_dir & m_out) | (~m_dir & m_s2);
      4'd7: return m_st;
      4'd8: return m_en;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      4'd6: return "R4";
      4'd7: return "R5/R6/R7/R8/R11";
      4'd8: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic check_read(logic [3:0] a, string rq);
    req = 1'b0; we = 1'b0; addr = a;
    #1 check(rq, rdata, m_read(a));
  endtask

  task automatic check_pins();
    check("R10", {31'd0, irq}, {31'd0, |(m_st & m_en)});
    check("R3", pad_o, m_out);
    check("R3", pad_oe, m_dir & ~m_mode);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      req = 1'b0; addr = 4'(a);
      #1 check("R1", (a == 6) ? 32'd0 : rdata, 32'd0);
    end
    check("R1", {31'd0, irq}, 32'd0);
    check("R1", pad_oe, 32'd0);

    // R2 writes to read-only words and strobes read zero
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
    check_read(4'd7, "R2"); check_read(4'd9, "R2"); check_read(4'd15, "R2");

    // R5 level low on line 3, clear cannot remove it
    wr(4'd2, 32'h8); wr(4'd0, 32'h8); wr(4'd10, 32'h8);
    idle(4);
    check_read(4'd7, "R5");
    check("R5", rdata & 32'h8, 32'h8);
    wr(4'd9, 32'h8);
    check_read(4'd7, "R5");
    check("R5", rdata & 32'h8, 32'h8);
    check_pins();
    wr(4'd0, 32'h0); wr(4'd2, 32'h0); idle(2);
    check_read(4'd7, "R11");

    // R7 both-edge on line 1, and R8 edge in same cycle as clear
    wr(4'd4, 32'h2); wr(4'd3, 32'h3); wr(4'd0, 32'h3); wr(4'd8, 32'h3);
    idle(2);
    @(negedge clk); pad = 32'h2;       // edge reaches detector 3 edges later
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd9; wdata = 32'h2; // clear lands on that edge
    @(negedge clk); req = 1'b0; we = 1'b0;
    check_read(4'd7, "R8");
    check("R8", rdata & 32'h2, 32'h2);
    wr(4'd9, 32'h0);                   // zeros leave it set
    check_read(4'd7, "R8");
    wr(4'd9, 32'h2);
    check_read(4'd7, "R8");
    check("R8", rdata & 32'h2, 32'h0);
    pad = 32'h0; idle(4);              // falling edge with polarity 0
    check_read(4'd7, "R7");
    check("R7", rdata & 32'h2, 32'h2);
    check_pins();

    // R4 output readback on line 0
    wr(4'd0, 32'h0); wr(4'd5, 32'h1); wr(4'd1, 32'h1); pad = 32'h0; idle(3);
    check_read(4'd6, "R4");
    check("R4", rdata & 32'h1, 32'h1);
    check_pins();

    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      pad = pad ^ ($urandom & $urandom & $urandom);
      req = 1'b0; we = 1'b0;
      if ($urandom_range(0, 9) < 4) begin
        int sel = $urandom_range(0, 13);
        req = 1'b1; we = 1'b1;
        addr = (sel > 10) ? 4'(($urandom_range(0, 1) == 0) ? 9 : 10) : 4'(sel);
        wdata = (addr == 4'd8) ? ($urandom & $urandom) : $urandom;
        #1 check_pins();
      end else begin
        logic [3:0] a = 4'($urandom_range(0, 15));
        addr = a;
        #1 check(req_of(a), rdata, m_read(a));
        check_pins();
      end
    end
    @(negedge clk); req = 1'b0; we = 1'b0;
    check_read(4'd7, "R6");
    check_read(4'd8, "R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule